// File: doc/BRIEF.md
# GHASH Field Multiplier

This block forms the product of two 128-bit values in the binary field used by GCM authentication, GF(2^128) modulo x^128 + x^7 + x^2 + x + 1. A one-cycle start pulse hands over the operand pair. The block samples both operands on that edge and works on its own copy. After a fixed latency a one-cycle done pulse marks the product on the result port.

The operands and the result use GCM bit order. Inside the block each operand is first byte-reversed. One 64x64 carry-less multiplier is then used four times, once per half-pair of the operands. The 256-bit product is shifted left by one bit to undo the reflected ordering. A two-phase shift-and-XOR reduction brings it back to 128 bits, and the result is byte-reversed once more on the way out. The block serves as the multiply step inside a GHASH accumulation loop. The loop, the hash-key derivation and the tag handling stay outside it.

Top module: `ghash_mul`

## Requirements
- R1: On the port, byte k of a 128-bit value sits at bits [8k+7:8k]. Within each byte, the most significant bit is the lower-degree coefficient, so bit 7 of byte 0 is the coefficient of x^0. result_o equals x_i times h_i in GF(2^128) modulo x^128 + x^7 + x^2 + x + 1.
- R2: done_o is high for exactly one cycle. It rises on the 5th rising edge after the edge that accepted start_i.
- R3: A start_i pulse that arrives while an operation is in progress is ignored. It changes neither the result nor the timing of the operation in flight.
- R4: The operands are sampled on the accepting edge. Later changes on x_i and h_i do not affect that operation's result.
- R5: result_o changes only on the edge that raises done_o. At all other times it holds its value.
- R6: While rst_ni is low, done_o is 0 and result_o is 0, and the block is idle.
- R7: If either operand is zero, the result is zero.
- R8: Multiplying by the field identity (port value 128'h80, the x^0 coefficient alone) returns the other operand unchanged.
- R9: A start_i on the cycle in which done_o is high is accepted. The new operation completes with the same latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request; accepted only when idle |
| x_i | input | 128 | First operand, GCM byte and bit order |
| h_i | input | 128 | Second operand (hash key), GCM byte and bit order |
| done_o | output | 1 | One-cycle pulse: result_o carries a new product |
| result_o | output | 128 | Product, GCM byte and bit order, held between pulses |

## Verification
The product of an accepted start is due on the fifth rising edge after acceptance. Before that edge, done_o must stay low and result_o must keep its previous value. The bench keeps its own model of busy state, a step count and the pending expected product. The model advances on each rising edge, and the expected product is computed bit-serially at acceptance. Both outputs are compared with the model on every falling edge, so an early, late or repeated pulse fails at the exact cycle it occurs. Starts that arrive while busy, operand changes during the operation and back-to-back starts are all covered by the same per-cycle comparison.

// File: rtl/ghash_pkg.sv
package ghash_pkg;
  localparam int BLK_W  = 128;
  localparam int LANE_W = 32;
  localparam int BYTE_W = 8;

  // which half of each operand feeds the multiplier: {x half, h half}
  typedef enum logic [1:0] {
    PP_LL = 2'd0,
    PP_LH = 2'd1,
    PP_HL = 2'd2,
    PP_HH = 2'd3
  } pp_sel_e;
endpackage

// File: rtl/ghash_bswap.sv
module ghash_bswap #(
  parameter int W      = 128,
  parameter int BYTE_W = 8
) (
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  localparam int NB = W / BYTE_W;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign d_o[g*BYTE_W +: BYTE_W] = d_i[(NB-1-g)*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/ghash_clmul.sv
module ghash_clmul #(
  parameter int W = 64
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  logic [2*W-1:0] pp [W];

  for (genvar g = 0; g < W; g++) begin : g_pp
    assign pp[g] = b_i[g] ? ({{W{1'b0}}, a_i} << g) : '0;
  end

  always_comb begin
    p_o = '0;
    for (int i = 0; i < W; i++) p_o = p_o ^ pp[i];
  end
endmodule

// File: rtl/ghash_reduce.sv
module ghash_reduce #(
  parameter int BLK_W  = 128,
  parameter int LANE_W = 32
) (
  input  logic [2*BLK_W-1:0] prod_i,
  output logic [BLK_W-1:0]   res_o
);
  localparam int NL   = BLK_W / LANE_W;
  // left shifts 31/30/25 pair with right shifts 1/2/7 (x^128 + x^7 + x^2 + x + 1)
  localparam int SL_A = LANE_W - 1;
  localparam int SL_B = LANE_W - 2;
  localparam int SL_C = LANE_W - 7;
  localparam int SR_A = 1;
  localparam int SR_B = 2;
  localparam int SR_C = 7;

  logic [2*BLK_W-1:0] aligned;
  logic [BLK_W-1:0]   lo, hi, t_vec, lo1, carry, u_vec;

  // undo reflected ordering
  assign aligned = prod_i << 1;
  assign lo      = aligned[BLK_W-1:0];
  assign hi      = aligned[2*BLK_W-1:BLK_W];

  for (genvar k = 0; k < NL; k++) begin : g_ph1
    logic [LANE_W-1:0] l;
    assign l = lo[k*LANE_W +: LANE_W];
    assign t_vec[k*LANE_W +: LANE_W] = (l << SL_A) ^ (l << SL_B) ^ (l << SL_C);
  end

  assign lo1   = lo ^ (t_vec << (BLK_W - LANE_W));
  assign carry = t_vec >> LANE_W;

  for (genvar k = 0; k < NL; k++) begin : g_ph2
    logic [LANE_W-1:0] l;
    assign l = lo1[k*LANE_W +: LANE_W];
    assign u_vec[k*LANE_W +: LANE_W] = (l >> SR_A) ^ (l >> SR_B) ^ (l >> SR_C);
  end

  assign res_o = u_vec ^ carry ^ lo1 ^ hi;
endmodule

// File: rtl/ghash_ctrl.sv
module ghash_ctrl
  import ghash_pkg::*;
#(
  parameter int NUM_PROD = 4
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  output logic    load_o,
  output logic    busy_o,
  output logic    acc_en_o,
  output logic    fin_o,
  output logic    done_o,
  output pp_sel_e sel_o
);
  localparam int STEP_W = $clog2(NUM_PROD + 1);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NUM_PROD);

  logic              busy_q, done_q;
  logic [STEP_W-1:0] step_q;

  assign load_o   = start_i && !busy_q;
  assign acc_en_o = busy_q && (step_q < LAST);
  assign fin_o    = busy_q && (step_q == LAST);
  assign sel_o    = pp_sel_e'(step_q[1:0]);
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          step_q <= '0;
        end
      end else if (step_q == LAST) begin
        busy_q <= 1'b0;
        step_q <= '0;
        done_q <= 1'b1;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ghash_mul.sv
module ghash_mul
  import ghash_pkg::*;
#(
  parameter int DW = 128,
  parameter int LW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [127:0]  x_i,
  input  logic [127:0]  h_i,
  output logic          done_o,
  output logic [127:0]  result_o
);
  localparam int HW       = DW / 2;
  localparam int NUM_PROD = 4;

  logic          load, busy, acc_en, fin;
  pp_sel_e       sel;
  logic [DW-1:0] x_sw, h_sw, red, red_sw;
  logic [DW-1:0] xs_q, hs_q, acc_lo_q, acc_mid_q, acc_hi_q, res_q;
  logic [HW-1:0] mul_a, mul_b;
  logic [DW-1:0] pp;
  logic [2*DW-1:0] wide;

  ghash_ctrl #(.NUM_PROD(NUM_PROD)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .busy_o  (busy),
    .acc_en_o(acc_en),
    .fin_o   (fin),
    .done_o  (done_o),
    .sel_o   (sel)
  );

  ghash_bswap #(.W(DW), .BYTE_W(BYTE_W)) u_sw_x (.d_i(x_i), .d_o(x_sw));
  ghash_bswap #(.W(DW), .BYTE_W(BYTE_W)) u_sw_h (.d_i(h_i), .d_o(h_sw));

  always_comb begin
    mul_a = (sel == PP_HL || sel == PP_HH) ? xs_q[DW-1:HW] : xs_q[HW-1:0];
    mul_b = (sel == PP_LH || sel == PP_HH) ? hs_q[DW-1:HW] : hs_q[HW-1:0];
  end

  ghash_clmul #(.W(HW)) u_clmul (.a_i(mul_a), .b_i(mul_b), .p_o(pp));

  assign wide = {acc_hi_q, acc_lo_q} ^ {{HW{1'b0}}, acc_mid_q, {HW{1'b0}}};

  ghash_reduce #(.BLK_W(DW), .LANE_W(LW)) u_red (.prod_i(wide), .res_o(red));

  ghash_bswap #(.W(DW), .BYTE_W(BYTE_W)) u_sw_r (.d_i(red), .d_o(red_sw));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xs_q      <= '0;
      hs_q      <= '0;
      acc_lo_q  <= '0;
      acc_mid_q <= '0;
      acc_hi_q  <= '0;
      res_q     <= '0;
    end else begin
      if (load) begin
        xs_q <= x_sw;
        hs_q <= h_sw;
      end else if (acc_en) begin
        unique case (sel)
          PP_LL: acc_lo_q  <= pp;
          PP_LH: acc_mid_q <= pp;
          PP_HL: acc_mid_q <= acc_mid_q ^ pp;
          PP_HH: acc_hi_q  <= pp;
        endcase
      end
      if (fin) res_q <= red_sw;
    end
  end

  assign result_o = res_q;
endmodule

// File: rtl/ghash_mul_chk.sv
module ghash_mul_chk (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         busy_i,
  input logic         done_i,
  input logic [127:0] result_i
);
  localparam logic [2:0] LAT = 3'd5;

  logic [2:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                lat_q <= '0;
    else if (start_i && !busy_i) lat_q <= 3'd1;
    else if (lat_q == LAT)      lat_q <= '0;
    else if (lat_q != '0)       lat_q <= lat_q + 3'd1;
  end

  a_r2_done_due: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q == LAT) |=> done_i);

  a_r2_done_only_when_due: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> ($past(lat_q) == LAT));

  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  a_r5_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> $stable(result_i));
endmodule

bind ghash_mul ghash_mul_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_i  (busy),
  .done_i  (done_o),
  .result_i(result_o)
);

// File: tb/sim_ghash_mul.sv
module sim_ghash_mul;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] x = '0, h = '0;
  logic         done;
  logic [127:0] res;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ghash_mul u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .x_i(x), .h_i(h), .done_o(done), .result_o(res)
  );

  function automatic logic [127:0] bswap(input logic [127:0] v);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) r[i*8 +: 8] = v[(15-i)*8 +: 8];
    return r;
  endfunction

  // bit-serial GCM multiply
  function automatic logic [127:0] gf_ref(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] xa, z, v;
    xa = bswap(a);
    v  = bswap(b);
    z  = '0;
    for (int i = 0; i < 128; i++) begin
      if (xa[127-i]) z = z ^ v;
      if (v[0]) v = (v >> 1) ^ {8'hE1, 120'd0};
      else      v = v >> 1;
    end
    return bswap(z);
  endfunction

  // cycle model
  bit           m_busy = 0, m_done = 0;
  int           m_cnt = 0;
  logic [127:0] m_res = '0, m_pend = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_res = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 5) begin
          m_busy = 0; m_done = 1; m_res = m_pend;
        end
      end else if (start) begin
        m_busy = 1; m_cnt = 0; m_pend = gf_ref(x, h);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(done === m_done, "R2 done timing", {127'd0, done}, {127'd0, m_done});
      chk(res === m_res, m_done ? "R1 product" : "R5 result hold", res, m_res);
    end
  end

  task automatic wait_done();
    bit seen = 0;
    for (int i = 0; i < 10 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(seen, "R2 done never seen", 128'd0, 128'd1);
  endtask

  task automatic op(input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    x = a; h = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [127:0] a, b, a2;
    repeat (3) @(negedge clk);
    // R6 reset state
    chk(done === 1'b0 && res === '0, "R6 reset outputs", res, 128'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7 zero operand
    a = {$urandom, $urandom, $urandom, $urandom};
    op(128'd0, a);
    chk(res === '0, "R7 zero x", res, 128'd0);
    op(a, 128'd0);
    chk(res === '0, "R7 zero h", res, 128'd0);

    // R8 identity element
    op(128'h80, a);
    chk(res === a, "R8 identity x", res, a);
    op(a, 128'h80);
    chk(res === a, "R8 identity h", res, a);

    // R1 random vectors
    for (int n = 0; n < 20; n++) begin
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      op(a, b);
      chk(res === gf_ref(a, b), "R1 random product", res, gf_ref(a, b));
    end

    // R3 start while busy ignored
    a = {$urandom, $urandom, $urandom, $urandom};
    b = {$urandom, $urandom, $urandom, $urandom};
    @(negedge clk); x = a; h = b; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); x = ~a; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();
    chk(res === gf_ref(a, b), "R3 busy start ignored", res, gf_ref(a, b));
    repeat (3) @(negedge clk);
    chk(done === 1'b0, "R3 no extra done", {127'd0, done}, 128'd0);

    // R4 operands changed during operation
    a = {$urandom, $urandom, $urandom, $urandom};
    b = {$urandom, $urandom, $urandom, $urandom};
    @(negedge clk); x = a; h = b; start = 1'b1;
    @(negedge clk); start = 1'b0; x = b; h = ~a;
    wait_done();
    chk(res === gf_ref(a, b), "R4 operands sampled at start", res, gf_ref(a, b));

    // R9 back-to-back start on the done cycle
    a  = {$urandom, $urandom, $urandom, $urandom};
    a2 = {$urandom, $urandom, $urandom, $urandom};
    b  = {$urandom, $urandom, $urandom, $urandom};
    op(a, b);
    x = a2; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();
    chk(res === gf_ref(a2, b), "R9 back-to-back product", res, gf_ref(a2, b));

    // R6 reset in mid operation
    @(negedge clk); x = a; h = b; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(done === 1'b0 && res === '0, "R6 reset mid-operation", res, 128'd0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(done === 1'b0 && res === '0, "R6 idle after reset", res, 128'd0);

    summary();
  end
endmodule